// File: doc/BRIEF.md
# Reference-Clock Timebase Prescaler

This block takes a 32768 Hz reference clock and turns it into a one-cycle increment strobe at an average rate of exactly 10 Hz. Downstream time-of-day counters and a "value changed" flag use this strobe. Everything runs in the reference clock domain. Each divider stage advances on a clock enable, and no divided clock drives any flop.

The chain has three stages. The first is a pulse-swallow stage that withholds one enable in every sixteen reference cycles, which gives an average of 30720 enables per second. The second is a binary divider that completes one pass every 512 enables, a 60 Hz event. The third is a three-flop Johnson ring that completes its six-state loop at 10 Hz. A synchroniser watches the rising edge of the ring's 10 Hz level and emits the strobe.

A run input stops and clears the whole chain. A test input bypasses the dividers so that the strobe fires on every reference cycle, which is useful for fast production checks of the counters fed by this block.

Top module: `xtal_prescaler`

## Requirements
- R1: While `run_i`=1 and `test_i`=0, `pre_en_o` is 0 in exactly one cycle out of every sixteen. That cycle is the sixteenth cycle counted from the cycle in which running began: cycles 15, 31, 47 and so on, with the first running cycle numbered 0. `pre_en_o` is 1 in every other running cycle.
- R2: `tick60_o` is 1 in the cycle that carries the 512th, 1024th, … enable since the start. It is 0 in every other cycle.
- R3: `slow10_o` is 1 while the number of completed 512-enable passes, taken modulo 6, is 0, 1 or 2. It is 0 while that number is 3, 4 or 5. The ring never holds a code that is not one of its six Johnson states.
- R4: In divide mode, `tick_o` is 1 for exactly one cycle. That cycle follows the clock edge that carried the 3072nd, 6144th, … enable. The first strobe is seen 3276 cycles after running starts, and exactly ten strobes occur in 32768 cycles.
- R5: With `run_i`=0, `tick_o`, `pre_en_o` and `tick60_o` are 0 and every stage is held at zero. When `run_i` rises again, the first strobe comes a full period later, at cycle 3276.
- R6: With `run_i`=1 and `test_i`=1, `tick_o` is 1 in every cycle and `pre_en_o` and `tick60_o` are 0. All stages hold their counts, and division resumes from the held state when `test_i` falls.
- R7: With `run_i`=0, `tick_o` stays 0 even when `test_i`=1.
- R8: An active-low asynchronous `rst_n` clears every stage. During reset with `run_i`=0, `tick_o`, `pre_en_o` and `tick60_o` are 0 and `slow10_o` is 1. After reset is released while `run_i`=1, the first strobe comes at cycle 3276.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | 32768 Hz reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | 1 = chain runs, 0 = chain stopped and cleared |
| test_i | input | 1 | 1 = bypass the dividers and feed the reference straight to the strobe |
| pre_en_o | output | 1 | Enable leaving the pulse-swallow stage (30720 Hz average) |
| tick60_o | output | 1 | Enable that completes a pass of the 512 divider (60 Hz) |
| slow10_o | output | 1 | 10 Hz level taken from the Johnson ring |
| tick_o | output | 1 | One-cycle increment strobe (10 Hz, or every cycle in test mode) |

## Verification
The assertions check several properties on every clock. After a swallowed enable, the next running cycle is enabled. The 512 divider is back at zero after each 60 Hz event. The ring always holds a legal Johnson code. A divide-mode strobe lasts one cycle and comes right after a 60 Hz event taken from the ring's last state. Stop keeps all stages at zero and all strobes low. Bypass forces the strobe and freezes every count. Other behaviour can only be shown by the bench's scenarios against its cycle-counting model. These are the absolute spacing of the strobes (first at 3276 cycles, ten per 32768), the exact cycle of each swallowed enable, the resumption of the count after a test-mode interlude, and the full-period wait after a restart or a reset.

// File: rtl/xp_pkg.sv
`timescale 1ns/1ps
package xp_pkg;

  // Operating mode decoded from the two control inputs.
  typedef enum logic [1:0] {
    XP_HALT   = 2'd0,
    XP_BYPASS = 2'd1,
    XP_DIVIDE = 2'd2
  } xp_mode_e;

  // Widest Johnson ring the legality check handles.
  localparam int XP_MAXW = 16;

  function automatic xp_mode_e xp_decode_mode(input logic run, input logic test);
    if (!run)      return XP_HALT;
    else if (test) return XP_BYPASS;
    else           return XP_DIVIDE;
  endfunction

  // A Johnson code of width w has at most one boundary between
  // neighbouring bits of differing value (a single block of ones).
  function automatic logic xp_johnson_ok(input logic [XP_MAXW-1:0] s, input int w);
    int flips;
    flips = 0;
    for (int i = 0; i < XP_MAXW - 1; i++) begin
      if (i < w - 1 && s[i] != s[i+1]) flips++;
    end
    return (flips <= 1);
  endfunction

endpackage

// File: rtl/xp_swallow.sv
`timescale 1ns/1ps
// Pulse-swallow stage: a free counter of the reference cycles that
// withholds the outgoing enable at one fixed count per wrap.
module xp_swallow #(
  parameter int unsigned CNT_W   = 4,
  parameter int unsigned SKIP_AT = (1 << CNT_W) - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             adv_i,
  output logic             pass_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] SKIP_CODE = CNT_W'(SKIP_AT);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (adv_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign pass_o = adv_i && (cnt_q != SKIP_CODE);
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/xp_bindiv.sv
`timescale 1ns/1ps
// Binary divider stage: counts enables, flags the one that wraps it.
module xp_bindiv #(
  parameter int unsigned DIV_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             adv_i,
  output logic             wrap_o,
  output logic [DIV_W-1:0] cnt_o
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (adv_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign wrap_o = adv_i && (&cnt_q);
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/xp_johnson.sv
`timescale 1ns/1ps
// Johnson ring stage: 2*STAGES states per loop. Any code outside the
// legal set is sent to zero on the next edge.
module xp_johnson
  import xp_pkg::*;
#(
  parameter int unsigned STAGES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              adv_i,
  output logic              level_o,
  output logic              last_o,
  output logic [STAGES-1:0] state_o
);
  localparam logic [STAGES-1:0] LAST_CODE = {1'b1, {(STAGES-1){1'b0}}};

  logic [STAGES-1:0]  q;
  logic [STAGES-1:0]  shifted;
  logic [XP_MAXW-1:0] q_wide;
  logic               legal;

  assign shifted[0] = ~q[STAGES-1];
  for (genvar g = 1; g < STAGES; g++) begin : g_shift
    assign shifted[g] = q[g-1];
  end

  assign q_wide = {{(XP_MAXW-STAGES){1'b0}}, q};
  assign legal  = xp_johnson_ok(q_wide, STAGES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= '0;
    else if (clr_i)  q <= '0;
    else if (!legal) q <= '0;
    else if (adv_i)  q <= shifted;
  end

  assign level_o = ~q[STAGES-1];
  assign last_o  = (q == LAST_CODE);
  assign state_o = q;
endmodule

// File: rtl/xtal_prescaler.sv
`timescale 1ns/1ps
module xtal_prescaler
  import xp_pkg::*;
#(
  parameter int unsigned SKIP_W      = 4,
  parameter int unsigned SKIP_SLOT   = (1 << SKIP_W) - 1,
  parameter int unsigned BIN_W       = 9,
  parameter int unsigned JOHN_STAGES = 3
) (
  input  logic clk_ref,
  input  logic rst_n,
  input  logic run_i,
  input  logic test_i,
  output logic pre_en_o,
  output logic tick60_o,
  output logic slow10_o,
  output logic tick_o
);
  // Named internal events, brought out for the bound checker.
  xp_mode_e               mode;
  logic                   halt;
  logic                   divide;
  logic                   bypass;
  logic [SKIP_W-1:0]      sw_cnt;
  logic [BIN_W-1:0]       bin_cnt;
  logic [JOHN_STAGES-1:0] john_q;
  logic                   john_last;
  logic                   level10;
  logic                   level10_prev;
  logic                   edge_seen;

  assign mode   = xp_decode_mode(run_i, test_i);
  assign halt   = (mode == XP_HALT);
  assign divide = (mode == XP_DIVIDE);
  assign bypass = (mode == XP_BYPASS);

  xp_swallow #(.CNT_W(SKIP_W), .SKIP_AT(SKIP_SLOT)) u_swallow (
    .clk   (clk_ref),
    .rst_n (rst_n),
    .clr_i (halt),
    .adv_i (divide),
    .pass_o(pre_en_o),
    .cnt_o (sw_cnt)
  );

  xp_bindiv #(.DIV_W(BIN_W)) u_bindiv (
    .clk   (clk_ref),
    .rst_n (rst_n),
    .clr_i (halt),
    .adv_i (pre_en_o),
    .wrap_o(tick60_o),
    .cnt_o (bin_cnt)
  );

  xp_johnson #(.STAGES(JOHN_STAGES)) u_johnson (
    .clk    (clk_ref),
    .rst_n  (rst_n),
    .clr_i  (halt),
    .adv_i  (tick60_o),
    .level_o(level10),
    .last_o (john_last),
    .state_o(john_q)
  );

  // Edge synchroniser: the cleared ring shows a high level, so the
  // history flop is also held high to avoid a strobe at start.
  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n)    level10_prev <= 1'b1;
    else if (halt) level10_prev <= 1'b1;
    else           level10_prev <= level10;
  end

  assign edge_seen = level10 & ~level10_prev;
  assign slow10_o  = level10;
  assign tick_o    = bypass | (divide & edge_seen);
endmodule

// File: rtl/xp_checker.sv
`timescale 1ns/1ps
module xp_checker
  import xp_pkg::*;
#(
  parameter int unsigned SKIP_W      = 4,
  parameter int unsigned BIN_W       = 9,
  parameter int unsigned JOHN_STAGES = 3
) (
  input logic                   clk_ref,
  input logic                   rst_n,
  input logic                   run_i,
  input logic                   test_i,
  input logic                   pre_en_o,
  input logic                   tick60_o,
  input logic                   tick_o,
  input logic [SKIP_W-1:0]      sw_cnt,
  input logic [BIN_W-1:0]       bin_cnt,
  input logic [JOHN_STAGES-1:0] john_q,
  input logic                   john_last
);
  logic [XP_MAXW-1:0] john_wide;
  assign john_wide = {{(XP_MAXW-JOHN_STAGES){1'b0}}, john_q};

  p_gap_refill_r1: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (run_i && !test_i && !pre_en_o) |=> (pre_en_o || !run_i || test_i));

  p_wrap_zero_r2: assert property (@(posedge clk_ref) disable iff (!rst_n)
    tick60_o |=> (bin_cnt == '0));

  p_john_legal_r3: assert property (@(posedge clk_ref) disable iff (!rst_n)
    xp_johnson_ok(john_wide, JOHN_STAGES));

  p_john_step_r3: assert property (@(posedge clk_ref) disable iff (!rst_n)
    tick60_o |=> !$stable(john_q));

  p_tick_single_r4: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (tick_o && !test_i) |=> (!tick_o || test_i));

  p_tick_cause_r4: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (tick_o && !test_i) |-> $past(tick60_o && john_last));

  p_halt_quiet_r5: assert property (@(posedge clk_ref) disable iff (!rst_n)
    !run_i |-> (!tick_o && !pre_en_o && !tick60_o));   // also covers R7

  p_halt_clears_r5: assert property (@(posedge clk_ref) disable iff (!rst_n)
    !run_i |=> (sw_cnt == '0 && bin_cnt == '0 && john_q == '0));

  p_bypass_feed_r6: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (run_i && test_i) |-> (tick_o && !pre_en_o && !tick60_o));

  p_bypass_hold_r6: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (run_i && test_i) |=> ($stable(sw_cnt) && $stable(bin_cnt) && $stable(john_q)));
endmodule

bind xtal_prescaler xp_checker #(
  .SKIP_W     (SKIP_W),
  .BIN_W      (BIN_W),
  .JOHN_STAGES(JOHN_STAGES)
) u_xp_checker (
  .clk_ref  (clk_ref),
  .rst_n    (rst_n),
  .run_i    (run_i),
  .test_i   (test_i),
  .pre_en_o (pre_en_o),
  .tick60_o (tick60_o),
  .tick_o   (tick_o),
  .sw_cnt   (sw_cnt),
  .bin_cnt  (bin_cnt),
  .john_q   (john_q),
  .john_last(john_last)
);

// File: tb/xtal_prescaler_bench.sv
`timescale 1ns/1ps
module xtal_prescaler_bench;
  localparam int CLK_PERIOD      = 10;
  localparam int WATCHDOG_CYCLES = 200000;
  localparam int ONE_SECOND      = 32768;
  localparam int FIRST_TICK_AT   = 3276;
  localparam int EN_PER_TICK     = 3072;

  logic clk_ref = 1'b0;
  logic rst_n   = 1'b0;
  logic run_i   = 1'b0;
  logic test_i  = 1'b0;
  logic pre_en_o, tick60_o, slow10_o, tick_o;

  int  checks = 0;
  int  errors = 0;
  bit  done   = 1'b0;

  // Behavioural model: running-cycle count, enable count, pending strobe.
  int  m_cycles  = 0;
  int  m_enables = 0;
  bit  m_pend    = 1'b0;
  bit  last_tick = 1'b0;

  always #(CLK_PERIOD/2) clk_ref = ~clk_ref;

  xtal_prescaler u_xtal_prescaler (
    .clk_ref (clk_ref),
    .rst_n   (rst_n),
    .run_i   (run_i),
    .test_i  (test_i),
    .pre_en_o(pre_en_o),
    .tick60_o(tick60_o),
    .slow10_o(slow10_o),
    .tick_o  (tick_o)
  );

  task automatic check_bit(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic check_int(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_cycles = 0; m_enables = 0; m_pend = 1'b0;
  endtask

  task automatic assert_reset();
    rst_n = 1'b0;
    model_reset();
  endtask

  // One clock: compare at the falling edge, then advance the model at the rising edge.
  task automatic cyc();
    bit    e_en, e_wrap, e_slow, e_tick;
    string treq;
    @(negedge clk_ref);
    e_en   = run_i && !test_i && ((m_cycles % 16) != 15);
    e_wrap = e_en && ((m_enables % 512) == 511);
    e_slow = ((m_enables / 512) % 6) < 3;
    e_tick = run_i && (test_i || m_pend);
    if (!run_i)      treq = test_i ? "R7" : "R5";
    else if (test_i) treq = "R6";
    else             treq = "R4";
    check_bit("R1", "pre_en_o", pre_en_o, e_en);
    check_bit("R2", "tick60_o", tick60_o, e_wrap);
    check_bit("R3", "slow10_o", slow10_o, e_slow);
    check_bit(treq, "tick_o",   tick_o,   e_tick);
    last_tick = (tick_o === 1'b1);
    @(posedge clk_ref);
    if (!rst_n || !run_i) begin
      model_reset();
    end else if (test_i) begin
      m_pend = 1'b0;
    end else begin
      e_en = (m_cycles % 16) != 15;
      m_cycles++;
      if (e_en) m_enables++;
      m_pend = e_en && ((m_enables % EN_PER_TICK) == 0);
    end
    #1;
  endtask

  task automatic first_tick(output int idx);
    idx = -1;
    for (int i = 0; i < 5000; i++) begin
      cyc();
      if (last_tick) begin
        idx = i;
        break;
      end
    end
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk_ref);
    if (!done) begin
      errors++;
      $display("FAIL R4 watchdog actual=%0d expected=finished", WATCHDOG_CYCLES);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int idx;
    int ticks;
    int first;
    assert_reset();
    repeat (3) cyc();
    // R8: reset state seen at the ports
    check_bit("R8", "tick_o in reset",   tick_o,   1'b0);
    check_bit("R8", "pre_en_o in reset", pre_en_o, 1'b0);
    check_bit("R8", "tick60_o in reset", tick60_o, 1'b0);
    check_bit("R8", "slow10_o in reset", slow10_o, 1'b1);
    rst_n = 1'b1;
    repeat (4) cyc();   // R5 idle while stopped

    // R4: first strobe position and count over one second
    run_i = 1'b1;
    ticks = 0; first = -1;
    for (int i = 0; i < ONE_SECOND; i++) begin
      cyc();
      if (last_tick) begin
        ticks++;
        if (first < 0) first = i;
      end
    end
    check_int("R4", "first strobe cycle", first, FIRST_TICK_AT);
    check_int("R4", "strobes per second", ticks, 10);

    // R6: bypass strobes every cycle, then division resumes
    test_i = 1'b1;
    ticks = 0;
    for (int i = 0; i < 20; i++) begin
      cyc();
      if (last_tick) ticks++;
    end
    check_int("R6", "bypass strobes", ticks, 20);
    test_i = 1'b0;
    repeat (4000) cyc();

    // R5: stop mid-period, restart waits a full period
    run_i = 1'b0;
    repeat (8) cyc();
    run_i = 1'b1;
    first_tick(idx);
    check_int("R5", "first strobe after restart", idx, FIRST_TICK_AT);

    // R7: stopped with test high gives no strobe
    run_i = 1'b0; test_i = 1'b1;
    ticks = 0;
    for (int i = 0; i < 6; i++) begin
      cyc();
      if (last_tick) ticks++;
    end
    check_int("R7", "strobes while stopped in test", ticks, 0);

    // R8: reset while running, then a full period to the first strobe
    test_i = 1'b0; run_i = 1'b1;
    repeat (1500) cyc();
    assert_reset();
    repeat (2) cyc();
    rst_n = 1'b1;
    first_tick(idx);
    check_int("R8", "first strobe after reset", idx, FIRST_TICK_AT);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule